// File: doc/BRIEF.md
# LRU-Tracking Lookup CAM

This block is a small, fully associative content-addressable memory for a multithreaded packet engine. It holds sixteen entries. Each entry has a 32-bit tag, four state bits owned by software, and a valid flag. A lookup compares a 32-bit key against every valid tag at the same time. The registered 9-bit result carries three things: a hit flag, an entry index, and the state bits of the entry that matched.

The block also keeps a full recency order across all entries. On a miss, the index field names the least-recently-used entry, so the caller gets a victim slot to refill without a second query. The write port loads a tag and state into a named entry. Both writes and hitting lookups move the touched entry to the most-recent position, which lets threads that share data keep hot entries resident.

Top module: `lru_cam`

## Requirements
- R1: A lookup strobe in cycle N produces `result_vld_o` high in cycle N+1 only. `result_o` then holds state in bits [8:5], the hit flag in bit [4] and the index in bits [3:0], and it keeps that value until the next lookup.
- R2: A lookup hits when some valid entry's tag equals the key. The index field is then that entry's number.
- R3: When several valid entries match, the lowest-numbered one is reported.
- R4: On a miss, bit [4] is 0, bits [8:5] are 0, and bits [3:0] give the least-recently-used entry.
- R5: On a hit, bits [8:5] return the state bits last written to the matching entry. State bits play no part in matching.
- R6: A hitting lookup moves the matched entry to the most-recently-used position and leaves the relative order of the others unchanged.
- R7: A write loads the tag and state of the entry named by `wr_idx_i`, marks it valid, and makes it most-recently-used.
- R8: A missing lookup with no write in the same cycle leaves the recency order unchanged.
- R9: After reset, no lookup result is pending and `result_o` is zero. All entries are invalid and never hit, even for key 0. The recency order runs from entry 0 (least recent) to entry 15 (most recent).
- R10: When a lookup and a write fall in the same cycle, the lookup sees the contents from before the write. The hit entry is touched first and the written entry second, so the written entry ends up most recent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lookup_i | input | 1 | Lookup strobe |
| key_i | input | 32 | Lookup key |
| wr_i | input | 1 | Entry write strobe |
| wr_idx_i | input | 4 | Entry to write |
| wr_tag_i | input | 32 | Tag to store |
| wr_state_i | input | 4 | State bits to store |
| result_o | output | 9 | Registered lookup result {state, hit, index} |
| result_vld_o | output | 1 | Result valid, one cycle after the strobe |

## Verification
The bench keeps the recency order as a queue and observes it through the victim index that misses return. A design that promotes an entry on a miss, or that fails to promote on a hit, reports the wrong victim on a later miss. Duplicate tags are written on purpose: a priority encoder that favours the highest match returns the wrong index and the wrong state. Same-cycle lookup and write checks that the lookup reads the old tag and that the written entry, not the hit entry, ends up most recent. Lookups of key 0 right after reset expose any design that lets an invalid all-zero entry match.

// File: rtl/cam_pkg.sv
package cam_pkg;
  localparam int unsigned CAM_ENTRIES = 16;
  localparam int unsigned CAM_TAG_W   = 32;
  localparam int unsigned CAM_STATE_W = 4;
  localparam int unsigned CAM_IDX_W   = $clog2(CAM_ENTRIES);
  localparam int unsigned CAM_RES_W   = CAM_STATE_W + 1 + CAM_IDX_W;

  typedef struct packed {
    logic [CAM_STATE_W-1:0] state;
    logic                   hit;
    logic [CAM_IDX_W-1:0]   idx;
  } cam_result_t;
endpackage

// File: rtl/cam_store.sv
module cam_store #(
  parameter int unsigned N       = cam_pkg::CAM_ENTRIES,
  parameter int unsigned TAG_W   = cam_pkg::CAM_TAG_W,
  parameter int unsigned STATE_W = cam_pkg::CAM_STATE_W,
  localparam int unsigned IDX_W  = $clog2(N)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_i,
  input  logic [IDX_W-1:0]           wr_idx_i,
  input  logic [TAG_W-1:0]           wr_tag_i,
  input  logic [STATE_W-1:0]         wr_state_i,
  output logic [N-1:0][TAG_W-1:0]    tag_o,
  output logic [N-1:0][STATE_W-1:0]  state_o,
  output logic [N-1:0]               valid_o
);
  logic [N-1:0][TAG_W-1:0]   tag_q;
  logic [N-1:0][STATE_W-1:0] state_q;
  logic [N-1:0]              valid_q;

  for (genvar g = 0; g < N; g++) begin : g_entry
    logic sel;
    assign sel = wr_i && (wr_idx_i == IDX_W'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        tag_q[g]   <= '0;
        state_q[g] <= '0;
        valid_q[g] <= 1'b0;
      end else if (sel) begin
        tag_q[g]   <= wr_tag_i;
        state_q[g] <= wr_state_i;
        valid_q[g] <= 1'b1;
      end
    end
  end

  assign tag_o   = tag_q;
  assign state_o = state_q;
  assign valid_o = valid_q;

  // R7: written entry becomes valid with new contents
  a_r7_write_loads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (valid_q[$past(wr_idx_i)] && tag_q[$past(wr_idx_i)] == $past(wr_tag_i)
              && state_q[$past(wr_idx_i)] == $past(wr_state_i)));
endmodule

// File: rtl/cam_match.sv
module cam_match #(
  parameter int unsigned N       = cam_pkg::CAM_ENTRIES,
  parameter int unsigned TAG_W   = cam_pkg::CAM_TAG_W,
  parameter int unsigned STATE_W = cam_pkg::CAM_STATE_W,
  localparam int unsigned IDX_W  = $clog2(N)
) (
  input  logic [TAG_W-1:0]           key_i,
  input  logic [N-1:0][TAG_W-1:0]    tag_i,
  input  logic [N-1:0][STATE_W-1:0]  state_i,
  input  logic [N-1:0]               valid_i,
  output logic                       hit_o,
  output logic [IDX_W-1:0]           idx_o,
  output logic [STATE_W-1:0]         state_o
);
  logic [N-1:0] match;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign match[g] = valid_i[g] && (tag_i[g] == key_i);
  end

  // lowest index wins: scan downward so the last assignment is the lowest
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (match[i]) idx_o = IDX_W'(i);
    end
  end

  assign hit_o   = |match;
  assign state_o = hit_o ? state_i[idx_o] : '0;
endmodule

// File: rtl/cam_lru.sv
module cam_lru #(
  parameter int unsigned N      = cam_pkg::CAM_ENTRIES,
  localparam int unsigned IDX_W = $clog2(N)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             touch_a_i,
  input  logic [IDX_W-1:0] touch_a_idx_i,
  input  logic             touch_b_i,
  input  logic [IDX_W-1:0] touch_b_idx_i,
  output logic [IDX_W-1:0] lru_idx_o
);
  localparam logic [IDX_W-1:0] RANK_MRU = IDX_W'(N - 1);

  // rank 0 = least recent, N-1 = most recent
  logic [N-1:0][IDX_W-1:0] rank_q, rank_a, rank_b;
  logic [N-1:0]            is_lru;

  always_comb begin
    rank_a = rank_q;
    if (touch_a_i) begin
      for (int j = 0; j < N; j++) begin
        if (IDX_W'(j) == touch_a_idx_i) rank_a[j] = RANK_MRU;
        else if (rank_q[j] > rank_q[touch_a_idx_i]) rank_a[j] = rank_q[j] - 1'b1;
      end
    end
    rank_b = rank_a;
    if (touch_b_i) begin
      for (int j = 0; j < N; j++) begin
        if (IDX_W'(j) == touch_b_idx_i) rank_b[j] = RANK_MRU;
        else if (rank_a[j] > rank_a[touch_b_idx_i]) rank_b[j] = rank_a[j] - 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int j = 0; j < N; j++) rank_q[j] <= IDX_W'(j);
    end else begin
      rank_q <= rank_b;
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_lru
    assign is_lru[g] = (rank_q[g] == '0);
  end

  always_comb begin
    lru_idx_o = '0;
    for (int i = 0; i < N; i++) begin
      if (is_lru[i]) lru_idx_o = IDX_W'(i);
    end
  end

  // R9: the order stays a permutation, so exactly one victim exists
  a_r9_single_lru: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(is_lru) == 1);
  // R8: no touch leaves the order alone
  a_r8_order_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!touch_a_i && !touch_b_i) |=> $stable(rank_q));
  // R7/R10: written entry ends most recent
  a_r7_write_mru: assert property (@(posedge clk_i) disable iff (!rst_ni)
    touch_b_i |=> rank_q[$past(touch_b_idx_i)] == RANK_MRU);
  // R6: sole hit touch ends most recent
  a_r6_hit_mru: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (touch_a_i && !touch_b_i) |=> rank_q[$past(touch_a_idx_i)] == RANK_MRU);
endmodule

// File: rtl/lru_cam.sv
module lru_cam
  import cam_pkg::*;
#(
  parameter int unsigned N       = CAM_ENTRIES,
  parameter int unsigned TAG_W   = CAM_TAG_W,
  parameter int unsigned STATE_W = CAM_STATE_W,
  localparam int unsigned IDX_W  = $clog2(N),
  localparam int unsigned RES_W  = STATE_W + 1 + IDX_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               lookup_i,
  input  logic [TAG_W-1:0]   key_i,
  input  logic               wr_i,
  input  logic [IDX_W-1:0]   wr_idx_i,
  input  logic [TAG_W-1:0]   wr_tag_i,
  input  logic [STATE_W-1:0] wr_state_i,
  output logic [RES_W-1:0]   result_o,
  output logic               result_vld_o
);
  logic [N-1:0][TAG_W-1:0]   tags;
  logic [N-1:0][STATE_W-1:0] states;
  logic [N-1:0]              valids;
  logic                      hit;
  logic [IDX_W-1:0]          hit_idx, lru_idx;
  logic [STATE_W-1:0]        hit_state;
  logic [RES_W-1:0]          res_q;
  logic                      vld_q;

  cam_store #(.N(N), .TAG_W(TAG_W), .STATE_W(STATE_W)) u_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (wr_i),
    .wr_idx_i   (wr_idx_i),
    .wr_tag_i   (wr_tag_i),
    .wr_state_i (wr_state_i),
    .tag_o      (tags),
    .state_o    (states),
    .valid_o    (valids)
  );

  cam_match #(.N(N), .TAG_W(TAG_W), .STATE_W(STATE_W)) u_match (
    .key_i   (key_i),
    .tag_i   (tags),
    .state_i (states),
    .valid_i (valids),
    .hit_o   (hit),
    .idx_o   (hit_idx),
    .state_o (hit_state)
  );

  cam_lru #(.N(N)) u_lru (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .touch_a_i     (lookup_i && hit),
    .touch_a_idx_i (hit_idx),
    .touch_b_i     (wr_i),
    .touch_b_idx_i (wr_idx_i),
    .lru_idx_o     (lru_idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= lookup_i;
      if (lookup_i) res_q <= {hit_state, hit, hit ? hit_idx : lru_idx};
    end
  end

  assign result_o     = res_q;
  assign result_vld_o = vld_q;

  // R1: valid pulse follows strobe by exactly one cycle
  a_r1_vld_timing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lookup_i |=> result_vld_o);
  a_r1_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lookup_i |=> (!result_vld_o && $stable(result_o)));
  // R4: miss carries no state
  a_r4_miss_clean: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (result_vld_o && !result_o[IDX_W]) |-> (result_o[RES_W-1:IDX_W+1] == '0));
endmodule

// File: tb/lru_cam_bench.sv
module lru_cam_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lookup = 1'b0;
  logic [31:0] key = '0;
  logic        wr = 1'b0;
  logic [3:0]  wr_idx = '0;
  logic [31:0] wr_tag = '0;
  logic [3:0]  wr_state = '0;
  logic [8:0]  result;
  logic        result_vld;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [31:0] m_tag [16];
  logic [3:0]  m_st  [16];
  bit          m_val [16];
  int          order [$];

  bit         p_vld = 0;
  logic [8:0] p_res = '0;
  string      p_req = "R1";

  always #2 clk = ~clk;

  lru_cam u_lru_cam (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .lookup_i     (lookup),
    .key_i        (key),
    .wr_i         (wr),
    .wr_idx_i     (wr_idx),
    .wr_tag_i     (wr_tag),
    .wr_state_i   (wr_state),
    .result_o     (result),
    .result_vld_o (result_vld)
  );

  task automatic touch(int e);
    foreach (order[k]) if (order[k] == e) begin order.delete(k); break; end
    order.push_back(e);
  endtask

  task automatic compare_pending();
    checks++;
    if (result_vld !== p_vld || (p_vld && result !== p_res)) begin
      failures++;
      $display("FAIL %s vld/result actual=%0b/%h expected=%0b/%h",
               p_req, result_vld, result, p_vld, p_res);
    end
  endtask

  // rq empty: label picked from the expected outcome
  task automatic step(string rq, bit lk, logic [31:0] k, bit w, int idx,
                      logic [31:0] tg, logic [3:0] st);
    int h;
    @(negedge clk);
    compare_pending();
    lookup = lk; key = k; wr = w; wr_idx = idx[3:0]; wr_tag = tg; wr_state = st;
    h = -1;
    for (int i = 0; i < 16; i++) if (m_val[i] && m_tag[i] == k) begin h = i; break; end
    p_vld = lk;
    if (lk) begin
      if (h >= 0) p_res = {m_st[h], 1'b1, 4'(h)};
      else        p_res = {4'b0, 1'b0, 4'(order[0])};
      p_req = (rq != "") ? rq : ((h >= 0) ? "R2" : "R4");
    end else if (rq != "") p_req = rq;
    else p_req = "R1";
    if (lk && h >= 0) touch(h);
    if (w) begin
      m_tag[idx] = tg; m_st[idx] = st; m_val[idx] = 1'b1;
      touch(idx);
    end
  endtask

  task automatic idle(); step("R1", 0, 32'h0, 0, 0, 32'h0, 4'h0); endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R1 watchdog actual=timeout expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) begin
      m_tag[i] = '0; m_st[i] = '0; m_val[i] = 1'b0; order.push_back(i);
    end
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R9: reset state
    @(negedge clk);
    checks++;
    if (result_vld !== 1'b0 || result !== 9'h0) begin
      failures++;
      $display("FAIL R9 reset actual=%0b/%h expected=0/000", result_vld, result);
    end
    step("R9", 1, 32'h0, 0, 0, 0, 0);            // invalid zero tags never hit, victim 0
    step("R9", 1, 32'h0, 0, 0, 0, 0);
    step("R7", 0, 0, 1, 0, 32'hCAFE_0001, 4'h5);
    step("R7", 1, 32'h1234, 0, 0, 0, 0);         // victim now 1
    step("R5", 1, 32'hCAFE_0001, 0, 0, 0, 0);    // hit 0, state 5
    step("R3", 0, 0, 1, 3, 32'hCAFE_0001, 4'h9);
    step("R3", 1, 32'hCAFE_0001, 0, 0, 0, 0);    // lowest index 0
    step("R8", 1, 32'h5555, 0, 0, 0, 0);
    step("R8", 1, 32'h6666, 0, 0, 0, 0);         // still victim 1
    step("R1", 0, 0, 0, 0, 0, 0);
    step("R1", 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 16; i++) step("R7", 0, 0, 1, i, 32'h100 + i, 4'(i));
    step("R7", 1, 32'hDEAD, 0, 0, 0, 0);         // victim 0
    step("R6", 1, 32'h100, 0, 0, 0, 0);          // hit 0 -> MRU
    step("R6", 1, 32'hDEAD, 0, 0, 0, 0);         // victim 1
    step("R10", 1, 32'h101, 1, 2, 32'h202, 4'hA); // hit 1 then write 2
    step("R10", 1, 32'hDEAD, 0, 0, 0, 0);        // victim 3
    step("R10", 1, 32'h105, 1, 5, 32'h305, 4'h3); // sees old tag of 5
    step("R10", 1, 32'h105, 0, 0, 0, 0);         // now misses
    for (int n = 0; n < 3000; n++) begin
      bit lk, w;
      logic [31:0] k;
      int sel;
      lk  = ($urandom % 3) != 0;
      w   = ($urandom % 4) == 0;
      sel = $urandom % 16;
      k   = ($urandom % 2) ? m_tag[sel] : (32'h1000 + ($urandom % 8));
      step("", lk, k, w, $urandom % 16, 32'h1000 + ($urandom % 8), 4'($urandom));
    end
    idle();
    idle();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule